// File: doc/BRIEF.md
# Interlace-Aware Vertical Capture Window

This block produces the vertical active-window enable for a video capture path. It counts incoming lines from the start of each frame or field. The count restarts on the rising edge of vertical sync and advances on every rising edge of horizontal sync. Once the count reaches a programmed 11-bit start line, the window output rises. It then stays high until the next vertical sync. The end of the window and the vertical height are handled elsewhere.

The start line is written over a byte-wide write port as two bytes. A write to the low byte only fills a holding copy. The start value in use changes only when the high byte is written, and then it takes the held low byte and the new upper bits together.

For interlaced sources, one of the two fields can start one line later than the other. A field flag is taken either from an embedded-sync stream decoder or from the internal sync processor, and it can be inverted. The flag is captured once per field. An active-low enable and a field-select bit then decide whether this field gets the extra line.

There is no streaming data at this block's edge, so no valid/ready handshake is used. All pins are plain control levels, sampled on the clock. A register write takes effect on the clock edge where `wr_en` is high, and there is no back-pressure.

Top module: `vcap_window`

## Requirements
- R1: After reset, the control register, both start registers, the holding copy and the line count are all zero, and `win` is low. `win` stays low until the first vertical sync rising edge has been seen, whatever `hsync` does.
- R2: A write to address 1 (start low byte) only loads the holding copy. The window start in use does not change.
- R3: A write to address 2 (start high byte) loads the start value as {wr_data[2:0], holding copy} in one step. Bits wr_data[5:3] of that write, and wr_data[7:3] of a write to address 0, are written as zero.
- R4: A rising edge on `vsync` clears the line count and drops `win`. Each later rising edge on `hsync` adds one to the count. `win` rises on the clock after the count equals the effective start, and it stays high until the next `vsync` rising edge.
- R5: When control bit 0 (interlace, address 0) is 0, the effective start equals the programmed start in every field.
- R6: When interlace is 1, high-byte bit 7 is 0 (shift allowed, active low), and the captured field equals high-byte bit 6 (1 = odd, 0 = even), the effective start is the programmed start plus one. Otherwise, the effective start equals the programmed start.
- R7: Control bit 1 selects the field flag: 1 takes `fld_embedded`, 0 takes `fld_detect`.
- R8: Control bit 2 set to 1 inverts the selected flag. After this step, a value of 1 means the odd field.
- R9: The conditioned field flag is captured on the `vsync` rising edge and held for the whole field. Changes on the field inputs between vsync edges have no effect.
- R10: The shift-enable and field-select bits take effect from the clock after the high-byte write, including partway through a field.
- R11: If `hsync` and `vsync` rise on the same clock, the count ends at zero. The vsync edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 start low, 2 start high |
| wr_data | input | 8 | Register write data |
| hsync | input | 1 | Horizontal sync, active high, synchronous to clk |
| vsync | input | 1 | Vertical sync, active high, synchronous to clk |
| fld_embedded | input | 1 | Field flag from the embedded-sync decoder |
| fld_detect | input | 1 | Field flag from the sync processor |
| win | output | 1 | Vertical capture window enable |

## Verification
The assertions take the sync and field inputs to be already synchronous to `clk`. They also assume that software writes zero to the reserved register bits, and one property checks this assumption on every write.

The stimulus drives every input on the falling clock edge. Each sync pulse is held high for two clocks and low for at least three, so every rising edge is seen exactly once. One deliberate case raises `hsync` and `vsync` together.

The field inputs are changed only after a vsync pulse. This is how the bench shows that the field captured for a field is held until the next vsync.

// File: rtl/vcw_pkg.sv
package vcw_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_START_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_START_HI = 2'd2;

  // control register bit positions
  localparam int CTRL_ILACE = 0;
  localparam int CTRL_SRC   = 1;
  localparam int CTRL_POL   = 2;
  localparam int CTRL_USED  = 3;

  // start-high register bit positions for the field shift
  localparam int HI_SHIFT_OFF = 7;
  localparam int HI_SHIFT_ODD = 6;

  typedef struct packed {
    logic ilace;
    logic src_embedded;
    logic invert;
  } ctrl_t;

  typedef struct packed {
    logic shift_off;
    logic shift_odd;
  } shift_t;
endpackage

// File: rtl/vcw_regs.sv
module vcw_regs
  import vcw_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output shift_t            shift,
  output logic [LINE_W-1:0] start
);
  localparam int HI_W = LINE_W - LO_W;

  logic [LO_W-1:0] lo_hold_q;
  logic [LINE_W-1:0] start_q;
  ctrl_t ctrl_q;
  shift_t shift_q;

  logic wr_ctrl, wr_lo, wr_hi;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_lo   = wr_en && (wr_addr == ADDR_START_LO);
  assign wr_hi   = wr_en && (wr_addr == ADDR_START_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_hold_q <= '0;
      start_q   <= '0;
      ctrl_q    <= '0;
      shift_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.ilace        <= wr_data[CTRL_ILACE];
        ctrl_q.src_embedded <= wr_data[CTRL_SRC];
        ctrl_q.invert       <= wr_data[CTRL_POL];
      end
      if (wr_lo) lo_hold_q <= wr_data[LO_W-1:0];
      if (wr_hi) begin
        start_q           <= {wr_data[HI_W-1:0], lo_hold_q};
        shift_q.shift_off <= wr_data[HI_SHIFT_OFF];
        shift_q.shift_odd <= wr_data[HI_SHIFT_ODD];
      end
    end
  end

  assign ctrl  = ctrl_q;
  assign shift = shift_q;
  assign start = start_q;

  // A low-byte write must leave the working start untouched.
  assert_lo_no_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> $stable(start_q));

  // A control write must not disturb the start value.
  assert_ctrl_keeps_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> $stable(start_q));

  // Reserved bits are written as zero.
  assert_rsvd_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |-> (wr_data[HI_SHIFT_ODD-1:HI_W] == '0));
  assert_rsvd_ctrl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |-> (wr_data[DATA_W-1:CTRL_USED] == '0));
endmodule

// File: rtl/vcw_field.sv
module vcw_field
  import vcw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   vs_rise,
  input  ctrl_t  ctrl,
  input  shift_t shift,
  input  logic   fld_embedded,
  input  logic   fld_detect,
  output logic   shift_one
);
  logic raw_fld, cond_fld, odd_q;

  assign raw_fld  = ctrl.src_embedded ? fld_embedded : fld_detect;
  assign cond_fld = raw_fld ^ ctrl.invert;

  always_ff @(posedge clk) begin
    if (!rst_n)       odd_q <= 1'b0;
    else if (vs_rise) odd_q <= cond_fld;
  end

  assign shift_one = ctrl.ilace && !shift.shift_off && (odd_q == shift.shift_odd);

  // Field is captured only at the vsync edge and held for the field.
  assert_field_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(odd_q));
endmodule

// File: rtl/vcw_linecnt.sv
module vcw_linecnt #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [LINE_W-1:0] start,
  input  logic              shift_one,
  output logic              vs_rise,
  output logic              win
);
  localparam int CNT_W = LINE_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic hs_d, vs_d, hs_rise;
  logic [CNT_W-1:0] cnt_q, eff;
  logic armed_q, win_q;

  assign hs_rise = hsync && !hs_d;
  assign vs_rise = vsync && !vs_d;
  assign eff     = {1'b0, start} + {{(CNT_W-1){1'b0}}, shift_one};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_d    <= 1'b0;
      vs_d    <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      hs_d <= hsync;
      vs_d <= vsync;
      if (vs_rise) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        win_q   <= 1'b0;
      end else begin
        if (hs_rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (armed_q && cnt_q == eff) win_q <= 1'b1;
      end
    end
  end

  assign win = win_q;

  assert_vs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (cnt_q == '0 && !win_q));
  assert_vs_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && hs_rise) |=> (cnt_q == '0));
  assert_win_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !vs_rise) |=> win_q);
  assert_win_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_q) |-> ($past(cnt_q) == $past(eff)));
  assert_no_win_unarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !win_q);
endmodule

// File: rtl/vcap_window.sv
module vcap_window
  import vcw_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              fld_embedded,
  input  logic              fld_detect,
  output logic              win
);
  ctrl_t             ctrl;
  shift_t            shift;
  logic [LINE_W-1:0] start;
  logic              vs_rise;
  logic              shift_one;

  vcw_regs #(.LINE_W(LINE_W), .LO_W(LO_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .shift(shift), .start(start)
  );

  vcw_linecnt #(.LINE_W(LINE_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .start(start), .shift_one(shift_one), .vs_rise(vs_rise), .win(win)
  );

  vcw_field field_i (
    .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .ctrl(ctrl), .shift(shift),
    .fld_embedded(fld_embedded), .fld_detect(fld_detect), .shift_one(shift_one)
  );

  // Progressive input never shifts the start.
  assert_progressive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.ilace |-> !shift_one);
endmodule

// File: tb/vcap_window_tb_top.sv
`timescale 1ns/1ps
module vcap_window_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic hsync = 1'b0, vsync = 1'b0, fld_embedded = 1'b0, fld_detect = 1'b0;
  logic win;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vcap_window dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .fld_embedded(fld_embedded),
    .fld_detect(fld_detect), .win(win)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: win actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cfg(input logic il, input logic src, input logic pol,
                     input logic off, input logic odd, input int st);
    wr(2'd0, {5'b0, pol, src, il});
    wr(2'd1, st[7:0]);
    wr(2'd2, {off, odd, 3'b0, st[10:8]});
  endtask

  task automatic hs_pulse();
    hsync = 1'b1; repeat (2) @(negedge clk);
    hsync = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic vs_pulse(input logic emb, input logic det);
    vsync = 1'b1; fld_embedded = emb; fld_detect = det;
    repeat (2) @(negedge clk);
    vsync = 1'b0; repeat (3) @(negedge clk);
  endtask

  // One field: vsync, then n lines; field inputs flipped after the capture (R9).
  task automatic run_field(input logic emb, input logic det, input int eff,
                           input int n, input string req);
    vs_pulse(emb, det);
    fld_embedded = ~emb; fld_detect = ~det;
    check(win, eff == 0, req);
    for (int k = 1; k <= n; k++) begin
      hs_pulse();
      check(win, k >= eff, req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(win, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: start is zero but no vsync seen yet
    for (int k = 0; k < 3; k++) begin
      hs_pulse();
      check(win, 1'b0, "R1");
    end
    // R1: zero start after reset matches line 0 once vsync arrives
    run_field(1'b0, 1'b0, 0, 2, "R1");

    // R3 commit and R4 basic counting
    cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3);
    run_field(1'b0, 1'b0, 3, 5, "R4");
    // R2: low byte only -> start stays 3
    wr(2'd1, 8'd1);
    run_field(1'b0, 1'b0, 3, 5, "R2");
    // R3: high byte now commits held low byte 1
    wr(2'd2, 8'h80);
    run_field(1'b0, 1'b0, 1, 3, "R3");

    // R11: hsync and vsync rise together -> count 0
    hsync = 1'b1; vsync = 1'b1;
    repeat (2) @(negedge clk);
    hsync = 1'b0; vsync = 1'b0;
    repeat (3) @(negedge clk);
    check(win, 1'b0, "R11");
    hs_pulse();
    check(win, 1'b1, "R11");

    // Near-exhaustive sweep of field configuration, start = 2
    for (int c = 0; c < 128; c++) begin
      automatic logic il = c[0], src = c[1], pol = c[2], off = c[3], odd = c[4];
      automatic logic emb = c[5], det = c[6];
      automatic logic fld = (src ? emb : det) ^ pol;
      automatic int e = 2 + ((il && !off && (fld == odd)) ? 1 : 0);
      automatic string tag = !il ? "R5" : (pol ? "R8" : (src ? "R7" : "R6"));
      cfg(il, src, pol, off, odd, 2);
      run_field(emb, det, e, 4, tag);
      // same config, field seen as the other value
      run_field(~emb, ~det, 2 + ((il && !off && (~fld == odd)) ? 1 : 0), 4, "R9");
    end

    // R10: shift bits written mid-field take effect at once
    cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3);
    vs_pulse(1'b0, 1'b1);
    check(win, 1'b0, "R10");
    hs_pulse();
    check(win, 1'b0, "R10");
    wr(2'd2, {1'b0, 1'b1, 6'd0});
    for (int k = 2; k <= 5; k++) begin
      hs_pulse();
      check(win, k >= 4, "R10");
    end

    // Large starts using the upper bits
    cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 258);
    run_field(1'b1, 1'b0, 259, 261, "R6");
    cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2047);
    run_field(1'b0, 1'b0, 2047, 2049, "R3");
    cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2047);
    run_field(1'b0, 1'b1, 2048, 2050, "R8");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule